// File: doc/BRIEF.md
# Register File with Banked Stack Pointer

This block is the general-purpose register store of a small CPU datapath. It holds sixteen 32-bit registers and offers two combinational read ports and one clocked write port. Registers 1 to 15 are ordinary storage and may hold data or addresses without restriction. Register 0 is the stack pointer. It has no storage of its own: every access to index 0 is steered to one of two physical stack pointers, an interrupt one and a user one, picked by a select input that mirrors a status-word bit.

Exception logic gets side ports that read and write either stack pointer directly, whatever the select input says. A side write wins over a same-cycle port write that lands on the same physical stack pointer. A read of an index written in the same cycle returns the value that index will hold after the clock edge. A warning output goes high whenever the selected stack pointer is not a multiple of four.

Top module: `banked_sp_regfile`

## Requirements
- R1: After reset, all of registers 1 to 15 and both stack pointers are zero. Both read ports return 0 for every index, `isp_q` and `usp_q` are 0, and `sp_misalign` is 0.
- R2: A port write to index k (1..15) with `wr_en`=1 is stored at the clock edge. From the next cycle, a read of index k on either port returns that value.
- R3: Index 0 maps to the interrupt stack pointer (`isp_q`) when `sp_sel`=0 and to the user stack pointer (`usp_q`) when `sp_sel`=1. This holds for both reads and port writes.
- R4: Write-through bypass. In a cycle where index k is written, a read of index k on either port returns the value k will hold after the edge. For index 0 that value includes any side write to the selected stack pointer.
- R5: A side write (`isp_wr_en` or `usp_wr_en`) updates its stack pointer at the clock edge whatever `sp_sel` is. `isp_q` and `usp_q` always show the stored values.
- R6: When a side write and a port write to index 0 target the same physical stack pointer in one cycle, the side data is stored. When they target different stack pointers, both writes take effect.
- R7: Changing `sp_sel` moves no data between the banks. Index 0 accesses follow the `sp_sel` value present in the cycle of the access.
- R8: `sp_misalign` is 1 exactly when the stored selected stack pointer has bit 1 or bit 0 set.
- R9: A port write to an index from 1 to 15 leaves both stack pointers unchanged. A port write to index 0 leaves registers 1 to 15 unchanged. A stack pointer that no write targets keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_sel | input | 1 | Stack pointer select: 0 interrupt, 1 user |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Port write enable |
| wr_idx | input | 4 | Port write index |
| wr_data | input | 32 | Port write data |
| isp_wr_en | input | 1 | Side write enable, interrupt stack pointer |
| isp_wr_data | input | 32 | Side write data, interrupt stack pointer |
| usp_wr_en | input | 1 | Side write enable, user stack pointer |
| usp_wr_data | input | 32 | Side write data, user stack pointer |
| isp_q | output | 32 | Stored interrupt stack pointer |
| usp_q | output | 32 | Stored user stack pointer |
| sp_misalign | output | 1 | Selected stack pointer not a multiple of four |

## Verification
The assertions check, on every cycle, that ports 1 to 15 are stored, that side writes win over port writes on each stack pointer, and that the user stack pointer holds when nothing targets it. They also check that an unwarned index-0 read with no write pending has clear low bits. The bench scenarios are needed for the rest: the reset contents, the bypass values on both ports, the redirection of index 0 after `sp_sel` toggles, and the proof that no bank copy happens. A model compares every read port, side output and the warning flag in every random cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
   typedef enum logic {
      SP_INT = 1'b0,
      SP_USR = 1'b1
   } sp_bank_e;

   localparam int SP_BANKS = 2;
endpackage

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rb_data
);
   logic [DATA_W-1:0] rd_arr [NUM_REGS];

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      if (k == 0) begin : g_hole
         assign rd_arr[k] = '0;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && (widx == IDX_W'(k)))
               q <= wdata;
         end
         assign rd_arr[k] = q;
      end
   end

   assign ra_data = rd_arr[ra_idx];
   assign rb_data = rd_arr[rb_idx];

   // R2
   gpr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx != '0) |=> rd_arr[$past(widx)] == $past(wdata));
endmodule

// File: rtl/rf_sp_bank.sv
module rf_sp_bank
   import rf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sp_bank_e          sel,
   input  logic              port_we0,
   input  logic [DATA_W-1:0] port_wdata,
   input  logic              isp_we,
   input  logic [DATA_W-1:0] isp_wdata,
   input  logic              usp_we,
   input  logic [DATA_W-1:0] usp_wdata,
   output logic [DATA_W-1:0] isp_q,
   output logic [DATA_W-1:0] usp_q,
   output logic [DATA_W-1:0] sel_cur,
   output logic [DATA_W-1:0] sel_next
);
   logic [DATA_W-1:0] cur_v  [SP_BANKS];
   logic [DATA_W-1:0] next_v [SP_BANKS];

   for (genvar b = 0; b < SP_BANKS; b++) begin : g_bank
      logic              side_we;
      logic [DATA_W-1:0] side_d;
      logic              port_hit;
      logic [DATA_W-1:0] q;

      if (b == 0) begin : g_int
         assign side_we = isp_we;
         assign side_d  = isp_wdata;
      end else begin : g_usr
         assign side_we = usp_we;
         assign side_d  = usp_wdata;
      end

      assign port_hit = port_we0 && (sel == sp_bank_e'(b));

      always_comb begin
         if (side_we)
            next_v[b] = side_d;
         else if (port_hit)
            next_v[b] = port_wdata;
         else
            next_v[b] = q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else
            q <= next_v[b];
      end

      assign cur_v[b] = q;
   end

   assign isp_q    = cur_v[0];
   assign usp_q    = cur_v[1];
   assign sel_cur  = (sel == SP_USR) ? cur_v[1] : cur_v[0];
   assign sel_next = (sel == SP_USR) ? next_v[1] : next_v[0];

   // R6
   isp_side_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isp_we |=> isp_q == $past(isp_wdata));
   // R6
   usp_side_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      usp_we |=> usp_q == $past(usp_wdata));
   // R3
   isp_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_we0 && sel == SP_INT && !isp_we) |=> isp_q == $past(port_wdata));
   // R9
   usp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(usp_we || (port_we0 && sel == SP_USR)) |=> $stable(usp_q));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   parameter bit BYPASS = 1'b1
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] gpr_data,
   input  logic [DATA_W-1:0] sp_cur,
   input  logic [DATA_W-1:0] sp_next,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] data
);
   if (BYPASS) begin : g_through
      always_comb begin
         if (idx == '0)
            data = sp_next;
         else if (we && (widx == idx))
            data = wdata;
         else
            data = gpr_data;
      end
   end else begin : g_plain
      logic [DATA_W-1:0] unused_x;
      assign unused_x = sp_next ^ wdata ^ {{(DATA_W-1){1'b0}}, we} ^ DATA_W'(widx);
      assign data = (idx == '0) ? sp_cur : gpr_data;
   end
endmodule

// File: rtl/banked_sp_regfile.sv
module banked_sp_regfile
   import rf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_REGS   = 16,
   parameter int ALIGN_BITS = 2,
   parameter bit BYPASS     = 1'b1,
   localparam int IDX_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sp_sel,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              isp_wr_en,
   input  logic [DATA_W-1:0] isp_wr_data,
   input  logic              usp_wr_en,
   input  logic [DATA_W-1:0] usp_wr_data,
   output logic [DATA_W-1:0] isp_q,
   output logic [DATA_W-1:0] usp_q,
   output logic              sp_misalign
);
   initial begin
      if (NUM_REGS < 2 || NUM_REGS != (1 << IDX_W))
         $error("NUM_REGS must be a power of two of at least 2");
      if (ALIGN_BITS < 1 || ALIGN_BITS >= DATA_W)
         $error("ALIGN_BITS must lie in 1..DATA_W-1");
   end

   sp_bank_e          sel;
   logic [DATA_W-1:0] ga_data, gb_data, sp_cur, sp_next;
   logic              port_we0;

   assign sel      = sp_bank_e'(sp_sel);
   assign port_we0 = wr_en && (wr_idx == '0);

   rf_gpr_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_gpr (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
      .ra_idx(rd_a_idx), .ra_data(ga_data), .rb_idx(rd_b_idx), .rb_data(gb_data)
   );

   rf_sp_bank #(.DATA_W(DATA_W)) u_sp (
      .clk(clk), .rst_n(rst_n), .sel(sel), .port_we0(port_we0), .port_wdata(wr_data),
      .isp_we(isp_wr_en), .isp_wdata(isp_wr_data),
      .usp_we(usp_wr_en), .usp_wdata(usp_wr_data),
      .isp_q(isp_q), .usp_q(usp_q), .sel_cur(sp_cur), .sel_next(sp_next)
   );

   rf_read_port #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BYPASS(BYPASS)) u_rda (
      .idx(rd_a_idx), .gpr_data(ga_data), .sp_cur(sp_cur), .sp_next(sp_next),
      .we(wr_en), .widx(wr_idx), .wdata(wr_data), .data(rd_a_data)
   );

   rf_read_port #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BYPASS(BYPASS)) u_rdb (
      .idx(rd_b_idx), .gpr_data(gb_data), .sp_cur(sp_cur), .sp_next(sp_next),
      .we(wr_en), .widx(wr_idx), .wdata(wr_data), .data(rd_b_data)
   );

   assign sp_misalign = |sp_cur[ALIGN_BITS-1:0];

   // R8
   aligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == '0 && !wr_en && !isp_wr_en && !usp_wr_en && !sp_misalign)
         |-> rd_a_data[ALIGN_BITS-1:0] == '0);
   // R7
   sel_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_idx == '0 && !wr_en && !isp_wr_en && !usp_wr_en)
         |-> rd_b_data == (sp_sel ? usp_q : isp_q));
endmodule

// File: tb/banked_sp_regfile_test.sv
module banked_sp_regfile_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sp_sel = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, isp_q, usp_q;
   logic        wr_en = 1'b0, isp_wr_en = 1'b0, usp_wr_en = 1'b0;
   logic [31:0] wr_data = '0, isp_wr_data = '0, usp_wr_data = '0;
   logic        sp_misalign;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [31:0] m_gpr [16];
   logic [31:0] m_isp, m_usp;

   always #5 clk = ~clk;

   banked_sp_regfile uut (
      .clk(clk), .rst_n(rst_n), .sp_sel(sp_sel),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .isp_wr_en(isp_wr_en), .isp_wr_data(isp_wr_data),
      .usp_wr_en(usp_wr_en), .usp_wr_data(usp_wr_data),
      .isp_q(isp_q), .usp_q(usp_q), .sp_misalign(sp_misalign)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_sp_next();
      if (sp_sel) begin
         if (usp_wr_en) return usp_wr_data;
         if (wr_en && wr_idx == 0) return wr_data;
         return m_usp;
      end else begin
         if (isp_wr_en) return isp_wr_data;
         if (wr_en && wr_idx == 0) return wr_data;
         return m_isp;
      end
   endfunction

   function automatic logic [31:0] exp_read(logic [3:0] idx);
      if (idx == 0) return exp_sp_next();
      if (wr_en && wr_idx == idx) return wr_data;
      return m_gpr[idx];
   endfunction

   function automatic logic exp_mis();
      return sp_sel ? (|m_usp[1:0]) : (|m_isp[1:0]);
   endfunction

   function automatic string rd_tag(logic [3:0] idx);
      if (idx == 0) return "R3";
      if (wr_en && wr_idx == idx) return "R4";
      return "R2";
   endfunction

   task automatic idle();
      wr_en = 0; isp_wr_en = 0; usp_wr_en = 0;
   endtask

   task automatic check_all();
      chk({rd_tag(rd_a_idx), " port A"}, rd_a_data, exp_read(rd_a_idx));
      chk({rd_tag(rd_b_idx), " port B"}, rd_b_data, exp_read(rd_b_idx));
      chk("R5 isp_q", isp_q, m_isp);
      chk("R5 usp_q", usp_q, m_usp);
      chk("R8 misalign", {31'b0, sp_misalign}, {31'b0, exp_mis()});
   endtask

   task automatic tick();
      if (isp_wr_en) m_isp = isp_wr_data;
      else if (wr_en && wr_idx == 0 && !sp_sel) m_isp = wr_data;
      if (usp_wr_en) m_usp = usp_wr_data;
      else if (wr_en && wr_idx == 0 && sp_sel) m_usp = wr_data;
      if (wr_en && wr_idx != 0) m_gpr[wr_idx] = wr_data;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 16; i++) m_gpr[i] = '0;
      m_isp = '0; m_usp = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset contents on every index
      for (int i = 0; i < 16; i++) begin
         rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); #1;
         chk("R1 reset port A", rd_a_data, 32'h0);
         chk("R1 reset port B", rd_b_data, 32'h0);
      end
      chk("R1 reset isp", isp_q, 0);
      chk("R1 reset usp", usp_q, 0);
      chk("R1 reset misalign", {31'b0, sp_misalign}, 0);
      @(negedge clk);

      // R7 side-load both banks, toggle select, no copy
      isp_wr_en = 1; isp_wr_data = 32'h0000_0100;
      usp_wr_en = 1; usp_wr_data = 32'h0000_0203;
      tick(); idle();
      sp_sel = 0; rd_a_idx = 0; rd_b_idx = 0; #1;
      chk("R7 sel0 reads isp", rd_a_data, 32'h100);
      chk("R8 aligned isp no warn", {31'b0, sp_misalign}, 0);
      @(negedge clk);
      sp_sel = 1; #1;
      chk("R7 sel1 reads usp", rd_b_data, 32'h203);
      chk("R8 misaligned usp warns", {31'b0, sp_misalign}, 1);
      chk("R7 isp untouched by toggle", isp_q, 32'h100);
      @(negedge clk);

      // R6 same physical target: side data wins, bypass shows it
      sp_sel = 0; wr_en = 1; wr_idx = 0; wr_data = 32'hAAAA_0000;
      isp_wr_en = 1; isp_wr_data = 32'hBBBB_0000; #1;
      chk("R6 bypass shows side data", rd_a_data, 32'hBBBB_0000);
      tick(); idle(); #1;
      chk("R6 side wins isp", isp_q, 32'hBBBB_0000);
      @(negedge clk);
      // R6 different targets: both take
      sp_sel = 1; wr_en = 1; wr_idx = 0; wr_data = 32'hCCCC_0004;
      isp_wr_en = 1; isp_wr_data = 32'hDDDD_0008;
      tick(); idle(); #1;
      chk("R6 port write usp", usp_q, 32'hCCCC_0004);
      chk("R6 side write isp", isp_q, 32'hDDDD_0008);
      @(negedge clk);

      // R9 register write leaves stack pointers
      wr_en = 1; wr_idx = 5; wr_data = 32'h1234_5678;
      tick(); idle(); rd_a_idx = 5; #1;
      chk("R9 isp kept", isp_q, 32'hDDDD_0008);
      chk("R9 usp kept", usp_q, 32'hCCCC_0004);
      chk("R2 reg5 stored", rd_a_data, 32'h1234_5678);
      @(negedge clk);
      // R9 index-0 write leaves reg5, R4 both ports bypass
      wr_en = 1; wr_idx = 0; wr_data = 32'h0000_0FF0; rd_a_idx = 0; rd_b_idx = 0; #1;
      chk("R4 bypass port A idx0", rd_a_data, 32'h0FF0);
      chk("R4 bypass port B idx0", rd_b_data, 32'h0FF0);
      tick(); idle(); rd_b_idx = 5; #1;
      chk("R9 reg5 kept", rd_b_data, 32'h1234_5678);
      @(negedge clk);

      // random phase
      for (int c = 0; c < 4000; c++) begin
         rd_a_idx = 4'($urandom_range(0, 15));
         rd_b_idx = ($urandom_range(0, 3) == 0) ? rd_a_idx : 4'($urandom_range(0, 15));
         wr_en = ($urandom_range(0, 1) == 1);
         wr_idx = ($urandom_range(0, 3) == 0) ? rd_a_idx : 4'($urandom_range(0, 15));
         wr_data = $urandom;
         if ($urandom_range(0, 1) == 0) wr_data[1:0] = 2'b00;
         isp_wr_en = ($urandom_range(0, 9) == 0);
         isp_wr_data = $urandom & 32'hFFFF_FFFC | 32'($urandom_range(0, 1));
         usp_wr_en = ($urandom_range(0, 9) == 0);
         usp_wr_data = $urandom & 32'hFFFF_FFFC | 32'($urandom_range(0, 3));
         if ($urandom_range(0, 4) == 0) sp_sel = ~sp_sel;
         #1;
         check_all();
         tick();
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule